// File: doc/BRIEF.md
# Pipelined Microcoded Arithmetic Core

This block is a minimal processor for low-rate fixed-point arithmetic such as first-order filters. It has six 20-bit working registers. It runs a straight-line program held in the same memory as its Q1.19 operands. A start request sets the program counter to zero and fetches one word per clock on an instruction read port. A second read port serves operand loads, and a single write port stores results.

Each fetched word moves down a six-entry instruction shift register. Every stage looks only at its own entry and acts on it when the opcode belongs to that stage. Because of this, each opcode writes back in a fixed cycle. The core does not detect hazards, so programs place no-operations between dependent instructions. The number of no-operations needed is given in the requirements.

An end-of-program word stops fetching and produces a one-cycle done pulse. Stores that are already in the pipeline still complete during the following cycles.

Top module: `ucode_arith_core`

## Requirements
- R1: While reset is held, `running`, `done`, `instrRdEn`, `dataRdEn` and `wrEn` are all 0.
- R2: A `startReq` seen while idle makes the core request address 0 in the next cycle. The request address then rises by one every cycle while the core runs.
- R3: A `startReq` seen while running is ignored, and the fetch address keeps counting.
- R4: The word layout is as follows. Bits [19:16] hold the opcode: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 store, 5 load, 6 end. Register operations take the destination in [15:12], source A in [11:8] and source B in [7:4]. Load and store take the register in [15:12] and the memory address in [8:0].
- R5: Add writes A+B modulo 2^20 to the destination. An instruction fetched three or more words later sees the result.
- R6: Subtract writes A−B modulo 2^20, with the same spacing as add.
- R7: Multiply writes bits [38:19] of the signed 40-bit product of A and B. An instruction fetched four or more words later sees the result.
- R8: Load copies the addressed memory word into the register. An instruction fetched two or more words later sees it.
- R9: Store writes the selected register's value to the word address in [8:0].
- R10: An end word halts fetching and pulses `done` high for exactly one cycle. Words placed after it are not executed.
- R11: Opcodes 7 to 15, and cycles without a valid fetched word, act as no-operations.
- R12: Register indices 6 to 15 read as zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start the program at address 0 when idle |
| running | output | 1 | Fetch is enabled |
| done | output | 1 | One-cycle pulse when an end word is fetched |
| instrRdEn | output | 1 | Instruction read request |
| instrRdAddr | output | 9 | Instruction read address (program counter) |
| instrRdData | input | 20 | Instruction word, one cycle after the request |
| instrRdValid | input | 1 | `instrRdData` holds a returned word |
| dataRdEn | output | 1 | Operand read request (load) |
| dataRdAddr | output | 9 | Operand read address |
| dataRdData | input | 20 | Operand word, one cycle after the request |
| wrEn | output | 1 | Store write enable |
| wrAddr | output | 9 | Store address |
| wrData | output | 20 | Store data |

## Verification
Assertions check the fetch handshake on every cycle. A start from idle must request address 0 next. The address steps by exactly one for as long as the core runs. The done pulse lasts one cycle and coincides with fetch dropping. The bench scenarios are the only evidence for arithmetic results: wrap-around in add and subtract, Q1.19 products including the −1×−1 overflow, the minimum no-operation spacings, the invalid register indices, and the fact that words after the end marker are never executed.

// File: rtl/ucore_pkg.sv
package ucore_pkg;
  localparam int WORD_W  = 20;
  localparam int ADDR_W  = 9;
  localparam int IDX_W   = 4;
  localparam int REG_CNT = 6;

  // Field positions decoded by several stages
  localparam int OP_LSB  = 16;
  localparam int DST_LSB = 12;
  localparam int SA_LSB  = 8;
  localparam int SB_LSB  = 4;

  // Stage indices along the instruction shift register
  localparam int ST_ISSUE  = 1;
  localparam int ST_LDWB   = 2;
  localparam int ST_ALUWB  = 3;
  localparam int ST_MULWB  = 4;
  localparam int ST_STORE  = 5;
  localparam int PIPE_LEN  = ST_STORE + 1;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_MPY = 4'd3,
    OP_SAVE = 4'd4, OP_LOAD = 4'd5, OP_END = 4'd6
  } opcode_e;

  typedef struct packed {
    logic             aluLoad;
    logic             aluNeg;
    logic             mulLoad;
    logic [IDX_W-1:0] srcA;
    logic [IDX_W-1:0] srcB;
    logic             ldWe;
    logic [IDX_W-1:0] ldDst;
    logic             aluWe;
    logic [IDX_W-1:0] aluDst;
    logic             mulWe;
    logic [IDX_W-1:0] mulDst;
    logic [IDX_W-1:0] stSrc;
  } ctl_t;

  function automatic logic [3:0] opOf(input logic [WORD_W-1:0] w);
    return w[OP_LSB +: 4];
  endfunction
  function automatic logic [IDX_W-1:0] fld(input logic [WORD_W-1:0] w, input int lsb);
    return w[lsb +: IDX_W];
  endfunction
endpackage

// File: rtl/ucore_ctrl.sv
module ucore_ctrl
  import ucore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] instrRdData,
  input  logic              instrRdValid,
  output logic              running,
  output logic              done,
  output logic              instrRdEn,
  output logic [ADDR_W-1:0] instrRdAddr,
  output logic              dataRdEn,
  output logic [ADDR_W-1:0] dataRdAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output ctl_t              ctl
);
  logic              enabled;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] pipe [PIPE_LEN];
  logic [WORD_W-1:0] fetchWord;
  logic              isEnd;

  // Missing or ignored returns enter the pipeline as a no-op word
  assign fetchWord = (enabled && instrRdValid) ? instrRdData : '0;
  assign isEnd     = (opOf(fetchWord) == OP_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b0;
      pc      <= '0;
      done    <= 1'b0;
      for (int i = 0; i < PIPE_LEN; i++) pipe[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!enabled) begin
        if (startReq) begin
          enabled <= 1'b1;
          pc      <= '0;
        end
      end else if (isEnd) begin
        enabled <= 1'b0;
        done    <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
      pipe[0] <= fetchWord;
      for (int i = 1; i < PIPE_LEN; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign running     = enabled;
  assign instrRdEn   = enabled;
  assign instrRdAddr = pc;

  always_comb begin
    logic [3:0] opI, opL, opA, opM, opS;
    opI = opOf(pipe[ST_ISSUE]);
    opL = opOf(pipe[ST_LDWB]);
    opA = opOf(pipe[ST_ALUWB]);
    opM = opOf(pipe[ST_MULWB]);
    opS = opOf(pipe[ST_STORE]);
    ctl.aluLoad = (opI == OP_ADD) || (opI == OP_SUB);
    ctl.aluNeg  = (opI == OP_SUB);
    ctl.mulLoad = (opI == OP_MPY);
    ctl.srcA    = fld(pipe[ST_ISSUE], SA_LSB);
    ctl.srcB    = fld(pipe[ST_ISSUE], SB_LSB);
    ctl.ldWe    = (opL == OP_LOAD);
    ctl.ldDst   = fld(pipe[ST_LDWB], DST_LSB);
    ctl.aluWe   = (opA == OP_ADD) || (opA == OP_SUB);
    ctl.aluDst  = fld(pipe[ST_ALUWB], DST_LSB);
    ctl.mulWe   = (opM == OP_MPY);
    ctl.mulDst  = fld(pipe[ST_MULWB], DST_LSB);
    ctl.stSrc   = fld(pipe[ST_STORE], DST_LSB);
    dataRdEn    = (opI == OP_LOAD);
    dataRdAddr  = pipe[ST_ISSUE][ADDR_W-1:0];
    wrEn        = (opS == OP_SAVE);
    wrAddr      = pipe[ST_STORE][ADDR_W-1:0];
  end

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: done coincides with fetch being dropped
  a_r10_halt_fetch: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!instrRdEn && $past(instrRdEn)));
  // R2: start from idle requests address zero next cycle
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !running) |=> (instrRdEn && instrRdAddr == '0));
  // R2/R3: address steps by one while running, start requests notwithstanding
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> (instrRdAddr == $past(instrRdAddr) + 1'b1));
endmodule

// File: rtl/ucore_dpath.sv
module ucore_dpath
  import ucore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [WORD_W-1:0] dataRdData,
  output logic [WORD_W-1:0] wrData
);
  localparam int SEL_W  = $clog2(REG_CNT);
  localparam int PROD_W = 2 * WORD_W;

  logic [WORD_W-1:0] rfRd [REG_CNT];
  logic [WORD_W-1:0] rdA, rdB, rdS;
  logic [WORD_W-1:0] addA, addB, sumQ, mulA, mulB, mulRes;
  logic signed [PROD_W-1:0] prodQ;

  function automatic logic [WORD_W-1:0] readReg(input logic [IDX_W-1:0] idx,
                                                input logic [WORD_W-1:0] rf [REG_CNT]);
    if (idx < IDX_W'(REG_CNT)) return rf[idx[SEL_W-1:0]];
    return '0;
  endfunction

  always_comb begin
    rdA = readReg(ctl.srcA, rfRd);
    rdB = readReg(ctl.srcB, rfRd);
    rdS = readReg(ctl.stSrc, rfRd);
  end
  assign wrData = rdS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addA <= '0; addB <= '0; mulA <= '0; mulB <= '0;
      sumQ <= '0; prodQ <= '0; mulRes <= '0;
    end else begin
      if (ctl.aluLoad) begin
        addA <= rdA;
        addB <= ctl.aluNeg ? (~rdB + 1'b1) : rdB;
      end
      if (ctl.mulLoad) begin
        mulA <= rdA;
        mulB <= rdB;
      end
      sumQ   <= addA + addB;
      prodQ  <= $signed(mulA) * $signed(mulB);
      mulRes <= prodQ[PROD_W-2 -: WORD_W];
    end
  end

  // One register per generate block; the oldest instruction wins a collision
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       q <= '0;
      else if (ctl.mulWe && ctl.mulDst == IDX_W'(g))   q <= mulRes;
      else if (ctl.aluWe && ctl.aluDst == IDX_W'(g))   q <= sumQ;
      else if (ctl.ldWe  && ctl.ldDst  == IDX_W'(g))   q <= dataRdData;
    end
    assign rfRd[g] = q;
  end

  // R12: an out-of-range store source presents zero
  a_r12_high_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stSrc >= IDX_W'(REG_CNT)) |-> (wrData == '0));
endmodule

// File: rtl/ucode_arith_core.sv
module ucode_arith_core
  import ucore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              running,
  output logic              done,
  output logic              instrRdEn,
  output logic [ADDR_W-1:0] instrRdAddr,
  input  logic [WORD_W-1:0] instrRdData,
  input  logic              instrRdValid,
  output logic              dataRdEn,
  output logic [ADDR_W-1:0] dataRdAddr,
  input  logic [WORD_W-1:0] dataRdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData
);
  ctl_t ctl;

  ucore_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .instrRdData(instrRdData), .instrRdValid(instrRdValid),
    .running(running), .done(done),
    .instrRdEn(instrRdEn), .instrRdAddr(instrRdAddr),
    .dataRdEn(dataRdEn), .dataRdAddr(dataRdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctl(ctl)
  );

  ucore_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dataRdData(dataRdData), .wrData(wrData)
  );
endmodule

// File: tb/sim_ucode_arith_core.sv
module sim_ucode_arith_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int MEMW = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        running, done, instrRdEn, dataRdEn, wrEn;
  logic [8:0]  instrRdAddr, dataRdAddr, wrAddr;
  logic [19:0] instrRdData, dataRdData, wrData;
  logic        instrRdValid;

  logic [19:0] mem [MEMW];
  logic        tbClr = 1'b0, tbWe = 1'b0;
  logic [8:0]  tbA = '0;
  logic [19:0] tbD = '0;

  int nChecks = 0, nFails = 0, doneSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_arith_core u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .running(running), .done(done),
    .instrRdEn(instrRdEn), .instrRdAddr(instrRdAddr), .instrRdData(instrRdData),
    .instrRdValid(instrRdValid), .dataRdEn(dataRdEn), .dataRdAddr(dataRdAddr),
    .dataRdData(dataRdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // Memory model: one-cycle read latency on both read ports
  always_ff @(posedge clk) begin
    if (tbClr)     for (int i = 0; i < MEMW; i++) mem[i] <= '0;
    else if (tbWe) mem[tbA] <= tbD;
    else if (wrEn) mem[wrAddr] <= wrData;
    instrRdValid <= rstN && instrRdEn;
    if (instrRdEn) instrRdData <= mem[instrRdAddr];
    if (dataRdEn)  dataRdData  <= mem[dataRdAddr];
  end

  // Vector table: operand A, operand B, opcode, expected result
  localparam logic [19:0] VA  [NVEC] = '{20'h12345, 20'h7FFFF, 20'h40000, 20'h10000,
                                         20'h40000, 20'hC0000, 20'h80000, 20'h7FFFF};
  localparam logic [19:0] VB  [NVEC] = '{20'h01111, 20'h00001, 20'h10000, 20'h40000,
                                         20'h40000, 20'h40000, 20'h80000, 20'h7FFFF};
  localparam logic [3:0]  VOP [NVEC] = '{4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd3, 4'd3, 4'd3};
  localparam logic [19:0] VEX [NVEC] = '{20'h13456, 20'h80000, 20'h30000, 20'hD0000,
                                         20'h20000, 20'hE0000, 20'h80000, 20'h7FFFE};

  function automatic logic [19:0] enc(input logic [3:0] op, input logic [3:0] d,
                                      input logic [3:0] a, input logic [3:0] b);
    return {op, d, a, b, 4'h0};
  endfunction
  function automatic logic [19:0] encM(input logic [3:0] op, input logic [3:0] r,
                                       input logic [8:0] addr);
    return {op, r, 3'b000, addr};
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    @(negedge clk); tbClr = 1'b1;
    @(negedge clk); tbClr = 1'b0;
  endtask
  task automatic put(input int a, input logic [19:0] d);
    @(negedge clk); tbWe = 1'b1; tbA = 9'(a); tbD = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  // Start, wait for done (bounded), then let in-flight stores drain
  task automatic runProg();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    doneSeen = 0;
    for (int t = 0; t < 400 && doneSeen == 0; t++) begin
      if (done) doneSeen++;
      @(negedge clk);
    end
    for (int t = 0; t < 12; t++) begin
      if (done) doneSeen++;
      @(negedge clk);
    end
    check("R10 done pulses", 20'(doneSeen), 20'd1);
    check("R10 fetch halted", {18'd0, running, instrRdEn}, 20'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {15'd0, running, done, instrRdEn, dataRdEn, wrEn}, 20'd0);
    rstN = 1'b1;

    // R2, R3: fetch sequencing with a program of no-ops
    clearMem();
    put(30, encM(4'd6, 4'd0, 9'd0));
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R2 first request", {10'd0, instrRdEn, instrRdAddr}, {10'd0, 1'b1, 9'd0});
    @(negedge clk);
    check("R2 address step", 20'(instrRdAddr), 20'd1);
    repeat (3) @(negedge clk);
    begin
      logic [8:0] held;
      held = instrRdAddr;
      startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      check("R3 start ignored", {10'd0, running, instrRdAddr}, {10'd0, 1'b1, held + 9'd1});
    end
    for (int t = 0; t < 100 && !done; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R10 halted after no-op run", 20'(running), 20'd0);

    // R4-R8, R10: vector table (R8: load-to-use with a single no-op)
    for (int v = 0; v < NVEC; v++) begin
      clearMem();
      put(0, encM(4'd5, 4'd1, 9'd100));
      put(1, encM(4'd5, 4'd2, 9'd101));
      put(3, enc(VOP[v], 4'd3, 4'd1, 4'd2));
      put(7, encM(4'd4, 4'd3, 9'd102));
      put(8, encM(4'd6, 4'd0, 9'd0));
      put(9, encM(4'd4, 4'd3, 9'd103));
      put(100, VA[v]); put(101, VB[v]);
      put(102, 20'h55555); put(103, 20'h33333);
      runProg();
      check($sformatf("R5/R6/R7/R9 vector %0d result", v), mem[102], VEX[v]);
      check("R10 word after end not run", mem[103], 20'h33333);
    end

    // R5, R7, R11: minimum spacings and an invalid opcode
    clearMem();
    put(0,  encM(4'd5, 4'd1, 9'd100));
    put(1,  encM(4'd5, 4'd2, 9'd101));
    put(3,  enc(4'd1, 4'd3, 4'd1, 4'd2));
    put(5,  20'hF3120);
    put(6,  enc(4'd1, 4'd4, 4'd3, 4'd3));
    put(10, enc(4'd3, 4'd5, 4'd4, 4'd1));
    put(14, enc(4'd2, 4'd3, 4'd5, 4'd1));
    put(15, encM(4'd4, 4'd5, 9'd107));
    put(16, encM(4'd4, 4'd3, 9'd106));
    put(17, encM(4'd6, 4'd0, 9'd0));
    put(100, 20'h01000); put(101, 20'h02000);
    runProg();
    check("R5/R7 chained multiply", mem[107], 20'h000C0);
    check("R6/R11 chained subtract", mem[106], 20'hFF0C0);

    // R12: out-of-range register indices
    clearMem();
    put(0, encM(4'd5, 4'd1, 9'd100));
    put(1, encM(4'd5, 4'd7, 9'd100));
    put(3, enc(4'd1, 4'd4, 4'd9, 4'd1));
    put(6, encM(4'd4, 4'd4, 9'd105));
    put(7, encM(4'd4, 4'd7, 9'd104));
    put(8, encM(4'd6, 4'd0, 9'd0));
    put(100, 20'h11111); put(104, 20'hABCDE);
    runProg();
    check("R12 high source reads zero", mem[105], 20'h11111);
    check("R12 high register dropped", mem[104], 20'h00000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule